// File: doc/BRIEF.md
# Board System Controller Register File

This block is the small control register file of a processor evaluation board. A host reaches it over a simple synchronous bus with separate read and write strobes and 32-bit data. Only the low 20 bits of the address select a register, so the block repeats across any larger window it is placed in.

It holds four groups of state:
- an 8-bit LED bar and an eight-character ASCII display buffer, both driven straight to the board;
- a break/reset byte and a general-purpose output byte;
- a bit-banged I2C port toward a serial EEPROM, whose SCL/SDA values leave with a one-cycle strobe and whose SDA comes back through an input register.

A magic-value write raises a one-cycle system reset request. A single write can load the whole display as the hexadecimal text of a 32-bit word. The general-purpose input register reads the I2C output value back when the select bit allows it.

Writes take effect at the clock edge that samples the write strobe, and outputs show the new value after that edge. Read data is combinational and valid while the read strobe is high. With no read strobe, `rdata_o` is zero.

Top module: `board_sysctl_regs`

## Requirements
- R1: After reset, the block holds these values:
  - LED bar 0x00, break byte 0x0A, GP output 0x00;
  - I2C output 0x3 (so SCL=1, SDA=1), I2C output-enable 0, I2C select 1, I2C input register 0x3;
  - all eight display characters 0x20 (space);
  - no reset request and no I2C strobe.
- R2: Only address bits [19:0] are decoded. Any value in the upper address bits reaches the same register.
- R3: Offsets with no register read as zero, and writes to them change no output or readable state. The display offsets (0x410, 0x418–0x450) and the soft-reset offset 0x500 are write-only and read zero.
- R4: The switch register (0x200) and the jumper register (0x210) always read zero, and writes to them are ignored.
- R5: The status register (0x208) reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R6: The LED bar register (0x408) stores bits [7:0] of a write, drives them on `led_o` from the next cycle, and reads them back zero-extended.
- R7: A write to 0x410 replaces all eight characters with the uppercase hexadecimal ASCII digits of the 32-bit write data. Character 0 gets bits [31:28] and character 7 gets bits [3:0]. Character k is `disp_o[8k+7:8k]`.
- R8: A write to offset 0x418 + 8·k (k = 0..7) sets character k to bits [7:0] of the write data. Offsets in that range that are not multiples of 8 are unmapped.
- R9: A write of exactly 0x00000042 to 0x500 raises `sys_rst_req_o` for exactly the one cycle after the write. Any other value raises nothing.
- R10: The break register (0x508) and the GP output register (0xA00) each keep bits [7:0] of a write and read them back zero-extended.
- R11: The I2C output-enable register (0xB08) keeps bits [1:0]. The I2C select register (0xB18) keeps bit 0.
- R12: A write to the I2C output register (0xB10) stores all 32 bits, which read back from 0xB10. From the next cycle it drives bit 1 on `scl_o` and bit 0 on `sda_o`, and it pulses `i2c_stb_o` for that one cycle.
- R13: The GP input register (0xA08) reads the stored I2C output word when select is 1 and reads zero when select is 0.
- R14: The I2C input register (0xB00) reads 0x2 with bit 0 replaced by the current `eeprom_sda_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (32) | Bus byte address; bits [19:0] decoded |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DW (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DW (32) | Combinational read data, zero when idle |
| led_o | output | 8 | LED bar value |
| disp_o | output | N_CHARS*CW (64) | Display characters, character k at bits [8k+7:8k] |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| scl_o | output | 1 | SCL value toward the EEPROM |
| sda_o | output | 1 | SDA value toward the EEPROM |
| i2c_stb_o | output | 1 | One-cycle strobe marking a new SCL/SDA value |
| eeprom_sda_i | input | 1 | SDA returned by the EEPROM |

## Verification
The bench goes after each corner case below; a wrong design shows the listed symptom.

| Corner case | What a wrong design does |
|---|---|
| Hex display word with digits above 9 | Produces lowercase letters or garbage between '9' and 'A' |
| Hex display word, digit order | Reversing the nibble order puts the least significant digit in character 0 |
| Offsets between two character slots, and just past the last slot | A loose decode overwrites a neighbouring character |
| Soft-reset value that differs from the magic only above bit 7 | A byte-wide compare raises a false reset request |
| Back-to-back writes | A latched request stays high longer than one cycle |
| Select bit cleared | GP input still leaks the I2C output |
| I2C input read while `eeprom_sda_i` toggles | Bit 0 shows the stored register instead of the live pin |
| Addresses with random upper bits | The block fails to alias across its window |

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned OFS_W = 20;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t OFS_SWITCH  = 20'h00200;
  localparam ofs_t OFS_STATUS  = 20'h00208;
  localparam ofs_t OFS_JUMPER  = 20'h00210;
  localparam ofs_t OFS_LED     = 20'h00408;
  localparam ofs_t OFS_HEXWORD = 20'h00410;
  localparam ofs_t OFS_CHAR0   = 20'h00418;
  localparam ofs_t OFS_SOFTRST = 20'h00500;
  localparam ofs_t OFS_BRK     = 20'h00508;
  localparam ofs_t OFS_GPOUT   = 20'h00A00;
  localparam ofs_t OFS_GPIN    = 20'h00A08;
  localparam ofs_t OFS_I2C_IN  = 20'h00B00;
  localparam ofs_t OFS_I2C_OE  = 20'h00B08;
  localparam ofs_t OFS_I2C_OUT = 20'h00B10;
  localparam ofs_t OFS_I2C_SEL = 20'h00B18;

  localparam int unsigned CHAR_SHIFT = 3;  // character slots are 8 bytes apart

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/sysctl_disp_buf.sv
module sysctl_disp_buf #(
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned CW      = 8,
  parameter int unsigned DW      = 32,
  localparam int unsigned IDX_W  = $clog2(N_CHARS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  word_we_i,
  input  logic                  char_we_i,
  input  logic [IDX_W-1:0]      char_idx_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N_CHARS*CW-1:0] chars_o
);
  import sysctl_pkg::*;

  localparam logic [CW-1:0] BLANK = CW'(8'h20);

  for (genvar k = 0; k < N_CHARS; k++) begin : g_char
    logic [CW-1:0] ch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_q <= BLANK;
      end else if (word_we_i) begin
        // character 0 takes the most significant nibble
        ch_q <= CW'(nib_to_ascii(wdata_i[DW-1-4*k -: 4]));
      end else if (char_we_i && char_idx_i == IDX_W'(k)) begin
        ch_q <= wdata_i[CW-1:0];
      end
    end
    assign chars_o[k*CW +: CW] = ch_q;
  end
endmodule

// File: rtl/sysctl_misc_regs.sv
module sysctl_misc_regs #(
  parameter int unsigned DW      = 32,
  parameter int unsigned BW      = 8,
  parameter logic [31:0] MAGIC   = 32'h0000_0042,
  parameter logic [7:0]  BRK_RST = 8'h0A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          led_we_i,
  input  logic          brk_we_i,
  input  logic          gp_we_i,
  input  logic          softrst_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [BW-1:0] led_q_o,
  output logic [BW-1:0] brk_q_o,
  output logic [BW-1:0] gp_q_o,
  output logic          rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q_o   <= '0;
      brk_q_o   <= BW'(BRK_RST);
      gp_q_o    <= '0;
      rst_req_o <= 1'b0;
    end else begin
      if (led_we_i) led_q_o <= wdata_i[BW-1:0];
      if (brk_we_i) brk_q_o <= wdata_i[BW-1:0];
      if (gp_we_i)  gp_q_o  <= wdata_i[BW-1:0];
      // full-width compare: 0x142 must not trigger
      rst_req_o <= softrst_we_i && (wdata_i == DW'(MAGIC));
    end
  end
endmodule

// File: rtl/sysctl_i2c_port.sv
module sysctl_i2c_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          out_we_i,
  input  logic          oe_we_i,
  input  logic          sel_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eeprom_sda_i,
  output logic [DW-1:0] out_q_o,
  output logic [1:0]    oe_q_o,
  output logic          sel_q_o,
  output logic [DW-1:0] in_word_o,
  output logic          scl_o,
  output logic          sda_o,
  output logic          stb_o
);
  localparam logic [DW-1:0] IO_RST = DW'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= IO_RST;
      oe_q_o  <= '0;
      sel_q_o <= 1'b1;
      stb_o   <= 1'b0;
    end else begin
      if (out_we_i) out_q_o <= wdata_i;
      if (oe_we_i)  oe_q_o  <= wdata_i[1:0];
      if (sel_we_i) sel_q_o <= wdata_i[0];
      stb_o <= out_we_i;
    end
  end

  assign scl_o     = out_q_o[1];
  assign sda_o     = out_q_o[0];
  // input register is never written; bit 0 follows the EEPROM pin live
  assign in_word_o = {IO_RST[DW-1:1], eeprom_sda_i};
endmodule

// File: rtl/board_sysctl_regs.sv
module board_sysctl_regs #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned N_CHARS    = 8,
  parameter int unsigned CW         = 8,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_en_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  rd_en_i,
  output logic [DW-1:0]         rdata_o,
  output logic [7:0]            led_o,
  output logic [N_CHARS*CW-1:0] disp_o,
  output logic                  sys_rst_req_o,
  output logic                  scl_o,
  output logic                  sda_o,
  output logic                  i2c_stb_o,
  input  logic                  eeprom_sda_i
);
  import sysctl_pkg::*;

  localparam int unsigned IDX_W     = $clog2(N_CHARS);
  localparam ofs_t        CHAR_SPAN = ofs_t'(N_CHARS << CHAR_SHIFT);
  localparam logic [DW-1:0] STATUS_VAL = BIG_ENDIAN ? DW'(8'h12) : DW'(8'h10);

  ofs_t ofs;
  ofs_t char_rel;
  logic char_hit;
  logic unused_addr_hi;

  assign ofs            = addr_i[OFS_W-1:0];
  assign unused_addr_hi = ^addr_i[AW-1:OFS_W];
  assign char_rel       = ofs - OFS_CHAR0;  // wraps high when below the window
  assign char_hit       = (char_rel < CHAR_SPAN) && (char_rel[CHAR_SHIFT-1:0] == '0);

  logic [7:0]    led_q, brk_q, gp_q;
  logic [DW-1:0] i2c_out_q, i2c_in_word;
  logic [1:0]    i2c_oe_q;
  logic          i2c_sel_q;

  sysctl_misc_regs #(.DW(DW), .BW(8)) u_misc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .led_we_i     (wr_en_i && ofs == OFS_LED),
    .brk_we_i     (wr_en_i && ofs == OFS_BRK),
    .gp_we_i      (wr_en_i && ofs == OFS_GPOUT),
    .softrst_we_i (wr_en_i && ofs == OFS_SOFTRST),
    .wdata_i      (wdata_i),
    .led_q_o      (led_q),
    .brk_q_o      (brk_q),
    .gp_q_o       (gp_q),
    .rst_req_o    (sys_rst_req_o)
  );

  sysctl_disp_buf #(.N_CHARS(N_CHARS), .CW(CW), .DW(DW)) u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_we_i  (wr_en_i && ofs == OFS_HEXWORD),
    .char_we_i  (wr_en_i && char_hit),
    .char_idx_i (char_rel[CHAR_SHIFT +: IDX_W]),
    .wdata_i    (wdata_i),
    .chars_o    (disp_o)
  );

  sysctl_i2c_port #(.DW(DW)) u_i2c (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .out_we_i     (wr_en_i && ofs == OFS_I2C_OUT),
    .oe_we_i      (wr_en_i && ofs == OFS_I2C_OE),
    .sel_we_i     (wr_en_i && ofs == OFS_I2C_SEL),
    .wdata_i      (wdata_i),
    .eeprom_sda_i (eeprom_sda_i),
    .out_q_o      (i2c_out_q),
    .oe_q_o       (i2c_oe_q),
    .sel_q_o      (i2c_sel_q),
    .in_word_o    (i2c_in_word),
    .scl_o        (scl_o),
    .sda_o        (sda_o),
    .stb_o        (i2c_stb_o)
  );

  assign led_o = led_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (ofs)
        OFS_STATUS:  rdata_o = STATUS_VAL;
        OFS_LED:     rdata_o = DW'(led_q);
        OFS_BRK:     rdata_o = DW'(brk_q);
        OFS_GPOUT:   rdata_o = DW'(gp_q);
        OFS_GPIN:    rdata_o = i2c_sel_q ? i2c_out_q : '0;
        OFS_I2C_IN:  rdata_o = i2c_in_word;
        OFS_I2C_OE:  rdata_o = DW'(i2c_oe_q);
        OFS_I2C_OUT: rdata_o = i2c_out_q;
        OFS_I2C_SEL: rdata_o = DW'(i2c_sel_q);
        default:     rdata_o = '0;  // switch, jumper, write-only and unmapped
      endcase
    end
  end
endmodule

// File: rtl/board_sysctl_regs_chk.sv
module board_sysctl_regs_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned CW      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [AW-1:0]         addr_i,
  input logic                  wr_en_i,
  input logic [DW-1:0]         wdata_i,
  input logic                  rd_en_i,
  input logic [DW-1:0]         rdata_o,
  input logic [7:0]            led_o,
  input logic [N_CHARS*CW-1:0] disp_o,
  input logic                  sys_rst_req_o,
  input logic                  scl_o,
  input logic                  sda_o,
  input logic                  i2c_stb_o,
  input logic                  eeprom_sda_i
);
  import sysctl_pkg::*;

  ofs_t ofs;
  logic disp_wr;
  assign ofs     = addr_i[OFS_W-1:0];
  assign disp_wr = wr_en_i && (ofs >= OFS_HEXWORD) && (ofs <= OFS_CHAR0 + ofs_t'((N_CHARS-1) << 3));

  assert_rst_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(wr_en_i && ofs == OFS_SOFTRST && wdata_i == DW'(32'h42)));

  assert_stb_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_stb_o |-> $past(wr_en_i && ofs == OFS_I2C_OUT));

  assert_stb_lines_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_stb_o |-> (scl_o == $past(wdata_i[1]) && sda_o == $past(wdata_i[0])));

  assert_led_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && ofs == OFS_LED) |-> $stable(led_o));

  assert_disp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(disp_wr) |-> $stable(disp_o));

  assert_switch_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (ofs == OFS_SWITCH || ofs == OFS_JUMPER)) |-> rdata_o == '0);

  assert_sda_live_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ofs == OFS_I2C_IN) |-> rdata_o[0] == eeprom_sda_i);

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

bind board_sysctl_regs board_sysctl_regs_chk #(
  .AW(AW), .DW(DW), .N_CHARS(N_CHARS), .CW(CW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rd_en_i       (rd_en_i),
  .rdata_o       (rdata_o),
  .led_o         (led_o),
  .disp_o        (disp_o),
  .sys_rst_req_o (sys_rst_req_o),
  .scl_o         (scl_o),
  .sda_o         (sda_o),
  .i2c_stb_o     (i2c_stb_o),
  .eeprom_sda_i  (eeprom_sda_i)
);

// File: tb/tb_board_sysctl_regs.sv
`timescale 1ns/1ps
module tb_board_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  led;
  logic [63:0] disp;
  logic        rst_req, scl, sda, stb;
  logic        ee_sda = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  board_sysctl_regs #(.BIG_ENDIAN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .led_o(led), .disp_o(disp),
    .sys_rst_req_o(rst_req), .scl_o(scl), .sda_o(sda), .i2c_stb_o(stb),
    .eeprom_sda_i(ee_sda)
  );

  // reference model
  logic [7:0]  m_led, m_brk, m_gp;
  logic [7:0]  m_ch [8];
  logic [31:0] m_out;
  logic [1:0]  m_oe;
  logic        m_sel;
  string       hexd = "0123456789ABCDEF";

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_disp();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = m_ch[k];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [19:0] o);
    case (o)
      20'h00208: return 32'h12;
      20'h00408: return {24'h0, m_led};
      20'h00508: return {24'h0, m_brk};
      20'h00A00: return {24'h0, m_gp};
      20'h00A08: return m_sel ? m_out : 32'h0;
      20'h00B00: return {30'h0, 1'b1, ee_sda};
      20'h00B08: return {30'h0, m_oe};
      20'h00B10: return m_out;
      20'h00B18: return {31'h0, m_sel};
      default:   return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_led = 8'h00; m_brk = 8'h0A; m_gp = 8'h00;
    m_out = 32'h3; m_oe = 2'b00; m_sel = 1'b1;
    for (int k = 0; k < 8; k++) m_ch[k] = 8'h20;
  endtask

  task automatic model_write(input logic [19:0] o, input logic [31:0] d);
    case (o)
      20'h00408: m_led = d[7:0];
      20'h00508: m_brk = d[7:0];
      20'h00A00: m_gp  = d[7:0];
      20'h00B08: m_oe  = d[1:0];
      20'h00B10: m_out = d;
      20'h00B18: m_sel = d[0];
      20'h00410: for (int k = 0; k < 8; k++) m_ch[k] = hexd[d[31-4*k -: 4]];
      default: begin
        if (o >= 20'h00418 && o <= 20'h00450 && o[2:0] == 3'b000)
          m_ch[(o - 20'h00418) >> 3] = d[7:0];
      end
    endcase
  endtask

  task automatic check_outputs(input string req, input logic exp_rst, input logic exp_stb);
    chk(req, "led_o", {56'h0, led}, {56'h0, m_led});
    chk(req, "disp_o", disp, m_disp());
    chk(req, "scl/sda", {62'h0, scl, sda}, {62'h0, m_out[1], m_out[0]});
    chk("R9", "sys_rst_req_o", {63'h0, rst_req}, {63'h0, exp_rst});
    chk("R12", "i2c_stb_o", {63'h0, stb}, {63'h0, exp_stb});
  endtask

  task automatic do_wr(input string req, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a[19:0], d);
    check_outputs(req, (a[19:0] == 20'h00500) && (d == 32'h42), a[19:0] == 20'h00B10);
  endtask

  task automatic do_rd(input string req, input logic [31:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    chk(req, $sformatf("read %h", a[19:0]), {32'h0, rdata}, {32'h0, exp_read(a[19:0])});
    rd_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [19:0] pick [20] = '{20'h00200, 20'h00208, 20'h00210, 20'h00408, 20'h00410,
                             20'h00418, 20'h00430, 20'h00450, 20'h0041C, 20'h00458,
                             20'h00500, 20'h00508, 20'h00A00, 20'h00A08, 20'h00B00,
                             20'h00B08, 20'h00B10, 20'h00B18, 20'h00504, 20'h00B14};

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_outputs("R1", 1'b0, 1'b0);
    chk("R1", "disp spaces", disp, {8{8'h20}});
    do_rd("R1", 32'h0000_0508);
    do_rd("R1", 32'h0000_0B10);
    do_rd("R1", 32'h0000_0B18);
    do_rd("R1", 32'h0000_0B08);
    do_rd("R13", 32'h0000_0A08);
    ee_sda = 1'b0; do_rd("R14", 32'h0000_0B00);
    ee_sda = 1'b1; do_rd("R14", 32'h0000_0B00);

    do_rd("R5", 32'h0000_0208);

    // R7 uppercase hex, MSB nibble to character 0
    do_wr("R7", 32'h0000_0410, 32'h9AB0_C3F1);
    chk("R7", "hex text", disp, {"1F3C0BA9"});

    // R8 single character, R3 gap offset ignored
    do_wr("R8", 32'h0000_0430, 32'h1234_5641);
    chk("R8", "char3", {56'h0, disp[31:24]}, {56'h0, 8'h41});
    do_wr("R3", 32'h0000_041C, 32'h0000_005A);
    do_wr("R3", 32'h0000_0458, 32'h0000_005A);
    do_rd("R3", 32'h0000_0418);

    // R9 exact magic, then one-cycle width
    do_wr("R9", 32'h0000_0500, 32'h0000_0042);
    @(negedge clk);
    chk("R9", "pulse width", {63'h0, rst_req}, 64'h0);
    do_wr("R9", 32'h0000_0500, 32'h0000_0142);

    // R2 upper address bits ignored
    do_wr("R2", 32'hFFF0_0408, 32'hFFFF_FFA5);
    do_rd("R6", 32'h1230_0408);

    // R12 full word stored, lines and strobe
    do_wr("R12", 32'h0000_0B10, 32'hDEAD_BEE6);
    do_rd("R12", 32'h0000_0B10);
    do_wr("R11", 32'h0000_0B08, 32'hFFFF_FFFF);
    do_rd("R11", 32'h0000_0B08);
    do_wr("R10", 32'h0000_0A00, 32'h1234_56C3);
    do_rd("R10", 32'h0000_0A00);

    // R13 select cleared hides loopback
    do_rd("R13", 32'h0000_0A08);
    do_wr("R11", 32'h0000_0B18, 32'h0000_0002);
    do_rd("R13", 32'h0000_0A08);

    // R4 switch and jumper
    do_wr("R4", 32'h0000_0200, 32'hFFFF_FFFF);
    do_wr("R4", 32'h0000_0210, 32'hFFFF_FFFF);
    do_rd("R4", 32'h0000_0200);
    do_rd("R4", 32'h0000_0210);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [19:0] o;
      logic [31:0] a, d;
      o = ($urandom % 8 == 0) ? 20'($urandom) : pick[$urandom % 20];
      a = {12'($urandom), o};
      d = ($urandom % 6 == 0) ? 32'h42 : $urandom;
      ee_sda = 1'($urandom);
      if ($urandom % 2 == 0) do_wr("R3/R6/R8/R10", a, d);
      else                   do_rd("R2/R13/R14", a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule